// File: doc/BRIEF.md
# SPI Burst Master Engine

This block is the serial heart of an SPI master. It runs one burst of 8-bit words at a time. It takes each outgoing byte from the pop side of a transmit FIFO and hands each incoming byte to the push side of a receive FIFO. It drives the serial clock, the data-out line and four chip-select lines, and it samples the data-in line. The FIFOs and the clock divider sit outside the block. A single-cycle `tick` input sets the pace: each tick moves the serial clock by one half period.

Software programs a control word, a 24-bit burst length and a 24-bit transmit length, then writes the control word again with its top bit set to start. The burst length is the number of bytes clocked on the wire. The transmit length is how many of those bytes are taken from the transmit FIFO; the bytes after that send zeros. For half-duplex commands the bytes received during the transmit phase can be thrown away. Chip select is either framed around the burst by the engine or held at a level that software chooses. The engine pulses `xfer_done` when the burst ends and clears its start bit.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset `sclk`, `mosi`, `cs_lines`, `ctrl_rdata`, `txf_pop`, `rxf_push` and `xfer_done` are all 0.
- R2: Control word fields: bit 0 phase, bit 1 clock idle level, bit 2 select polarity (1 means the lines are active-low), bits 5:4 select index, bit 6 manual select, bit 7 manual select level, bit 8 drop-receive, bit 12 LSB-first, bit 31 start/busy. `ctrl_rdata` returns these fields at the same positions and reads 0 in every other bit.
- R3: A burst clocks exactly burst-length bytes, which is 16 serial-clock transitions per byte. The count is 24 bits wide. At the end `xfer_done` is high for exactly one cycle and bit 31 reads 0 from the next cycle on.
- R4: The first min(burst, transmit) bytes are popped from the transmit FIFO, one pop per byte and in order. All later bytes of the burst send 0x00.
- R5: `sclk` rests at the level of bit 1 outside byte shifting. With phase 0, data out is valid before the leading edge and data in is sampled on the leading edge. With phase 1, data out changes on the leading edge and data in is sampled on the trailing edge.
- R6: With bit 12 = 0 each byte goes out and comes in MSB first; with bit 12 = 1 it goes LSB first. A received byte is pushed with the first bit on the wire in the same bit position it holds when sent.
- R7: With bit 8 set, the bytes whose index is below the transmit length are not pushed. Every byte after them is pushed. With bit 8 clear, all burst bytes are pushed.
- R8: With bit 6 clear, the line picked by bits 5:4 is active while the engine is busy, and every other line is at its inactive level (1 if bit 2 is set, else 0).
- R9: With bit 6 set, the selected line carries the raw level of bit 7 whether a burst runs or not, and every other line stays inactive.
- R10: While transmit bytes remain and the transmit FIFO is empty between bytes, the engine waits with `sclk` at its idle level and does not pop. It resumes when data arrives.
- R11: Writes to the control word or to either length register while busy are ignored.
- R12: A burst length of 0 produces the `xfer_done` pulse with no serial-clock activity and no FIFO traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-bit step enable |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| blen_we | input | 1 | Burst length write strobe |
| blen_wdata | input | 24 | Burst length in bytes |
| tlen_we | input | 1 | Transmit length write strobe |
| tlen_wdata | input | 24 | Transmit length in bytes |
| ctrl_rdata | output | 32 | Control word readback, bit 31 busy |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte (show-ahead) |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_data | output | 8 | Receive FIFO write byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_lines | output | 4 | Chip-select lines |
| xfer_done | output | 1 | Burst complete pulse |

## Verification
The bench sweeps every clock mode against both bit orders and five length patterns, including a transmit length longer than the burst and a pure receive burst with drop set. A slave model drives data in on the opposite edge, so a design that samples on the wrong edge returns bytes shifted by one bit. A design that loses the last sampled bit returns a wrong final byte. A design that pushes dropped bytes, or pops beyond the burst, gets its byte and pop counts compared against arithmetic expectations. Directed runs cover a FIFO that runs dry in mid-burst, where a design that keeps clocking shows extra edges during the wait. They also cover a zero-length burst, manual select with a burst running, and a control write while busy that a faulty design would let flip the clock level.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_W = 8;
  localparam int CS_N   = 4;
  localparam int CNT_W  = 24;
  localparam int IDX_W  = 2;

  typedef struct packed {
    logic             lsb_first;
    logic             rx_drop;
    logic             cs_lvl;
    logic             cs_man;
    logic [IDX_W-1:0] cs_idx;
    logic             cs_low;
    logic             cpol;
    logic             cpha;
  } xfer_cfg_t;

  // Field positions of the control word.
  localparam int B_CPHA = 0;
  localparam int B_CPOL = 1;
  localparam int B_CSLO = 2;
  localparam int B_IDX  = 4;
  localparam int B_MAN  = 6;
  localparam int B_LVL  = 7;
  localparam int B_DROP = 8;
  localparam int B_LSB  = 12;
  localparam int B_GO   = 31;

  function automatic xfer_cfg_t cfg_unpack(input logic [31:0] w);
    xfer_cfg_t c;
    c.cpha      = w[B_CPHA];
    c.cpol      = w[B_CPOL];
    c.cs_low    = w[B_CSLO];
    c.cs_idx    = w[B_IDX +: IDX_W];
    c.cs_man    = w[B_MAN];
    c.cs_lvl    = w[B_LVL];
    c.rx_drop   = w[B_DROP];
    c.lsb_first = w[B_LSB];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input xfer_cfg_t c, input logic busy);
    logic [31:0] w;
    w = '0;
    w[B_CPHA]         = c.cpha;
    w[B_CPOL]         = c.cpol;
    w[B_CSLO]         = c.cs_low;
    w[B_IDX +: IDX_W] = c.cs_idx;
    w[B_MAN]          = c.cs_man;
    w[B_LVL]          = c.cs_lvl;
    w[B_DROP]         = c.rx_drop;
    w[B_LSB]          = c.lsb_first;
    w[B_GO]           = busy;
    return w;
  endfunction

  // Puts the first wire bit at the MSB end of the shifter.
  function automatic logic [WORD_W-1:0] word_orient(input logic [WORD_W-1:0] d,
                                                    input logic lsb);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = d[WORD_W-1-i];
    return lsb ? r : d;
  endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_eng_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [31:0]   ctrl_wdata,
  input  logic          blen_we,
  input  logic [CW-1:0] blen_wdata,
  input  logic          tlen_we,
  input  logic [CW-1:0] tlen_wdata,
  input  logic          done,
  output xfer_cfg_t     cfg,
  output logic [CW-1:0] burst_len,
  output logic [CW-1:0] tx_len,
  output logic          busy,
  output logic          go,
  output logic [31:0]   ctrl_rdata
);
  assign go         = ctrl_we & ctrl_wdata[B_GO] & ~busy;
  assign ctrl_rdata = cfg_pack(cfg, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      burst_len <= '0;
      tx_len    <= '0;
      busy      <= 1'b0;
    end else begin
      if (!busy) begin
        if (ctrl_we) cfg       <= cfg_unpack(ctrl_wdata);
        if (blen_we) burst_len <= blen_wdata;
        if (tlen_we) tx_len    <= tlen_wdata;
      end
      if (go)        busy <= 1'b1;
      else if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_gen.sv
module spi_cs_gen
  import spi_eng_pkg::*;
#(
  parameter int N = CS_N
) (
  input  xfer_cfg_t    cfg,
  input  logic         active,
  output logic [N-1:0] cs_lines
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic sel;
    assign sel = (cfg.cs_idx == IDX_W'(g));
    assign cs_lines[g] = sel ? (cfg.cs_man ? cfg.cs_lvl : (active ^ cfg.cs_low))
                             : cfg.cs_low;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  xfer_cfg_t     cfg,
  input  logic [CW-1:0] burst_len,
  input  logic [CW-1:0] tx_len,
  input  logic          txf_empty,
  input  logic [W-1:0]  txf_data,
  output logic          txf_pop,
  input  logic          miso,
  output logic          rxf_push,
  output logic [W-1:0]  rxf_data,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          done,
  output logic          loading,
  output logic          shifting,
  output logic          tx_pending
);
  localparam int HC_W = $clog2(2 * W);
  localparam logic [HC_W-1:0] HMAX = HC_W'(2 * W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} st_t;

  st_t             st;
  logic [CW-1:0]   b_left, t_left;
  logic [HC_W-1:0] hcnt;
  logic            ph, mo;
  logic [W-1:0]    tx_sh, rx_sh, rx_full, next_byte;
  logic            lead_tick, trail_tick, shift_ev, samp_ev, last_tick, load_ok;

  assign loading    = (st == S_LOAD);
  assign shifting   = (st == S_SHIFT);
  assign active     = (st != S_IDLE);
  assign tx_pending = (t_left != '0);

  assign lead_tick  = tick & shifting & ~hcnt[0];
  assign trail_tick = tick & shifting &  hcnt[0];
  assign shift_ev   = cfg.cpha ? lead_tick  : trail_tick;
  assign samp_ev    = cfg.cpha ? trail_tick : lead_tick;
  assign last_tick  = tick & shifting & (hcnt == HMAX);

  assign done    = loading & (b_left == '0);
  assign load_ok = loading & (b_left != '0) & (~tx_pending | ~txf_empty);
  assign txf_pop = load_ok & tx_pending;

  assign next_byte = tx_pending ? word_orient(txf_data, cfg.lsb_first) : '0;
  assign rx_full   = samp_ev ? {rx_sh[W-2:0], miso} : rx_sh;
  assign rxf_push  = last_tick & ~(cfg.rx_drop & tx_pending);
  assign rxf_data  = word_orient(rx_full, cfg.lsb_first);

  assign sclk = cfg.cpol ^ ph;
  assign mosi = mo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      b_left <= '0;
      t_left <= '0;
      hcnt   <= '0;
      ph     <= 1'b0;
      mo     <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (go) begin
            b_left <= burst_len;
            t_left <= tx_len;
            st     <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (done) begin
            st <= S_IDLE;
            mo <= 1'b0;
          end else if (load_ok) begin
            hcnt <= '0;
            ph   <= 1'b0;
            st   <= S_SHIFT;
            if (cfg.cpha) begin
              tx_sh <= next_byte;
            end else begin
              mo    <= next_byte[W-1];
              tx_sh <= {next_byte[W-2:0], 1'b0};
            end
          end
        end
        S_SHIFT: begin
          if (tick) begin
            ph   <= ~ph;
            hcnt <= hcnt + 1'b1;
          end
          if (shift_ev) begin
            mo    <= tx_sh[W-1];
            tx_sh <= {tx_sh[W-2:0], 1'b0};
          end
          if (samp_ev) rx_sh <= rx_full;
          if (last_tick) begin
            b_left <= b_left - 1'b1;
            t_left <= tx_pending ? t_left - 1'b1 : '0;
            st     <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_eng_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W,
  parameter int N  = CS_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ctrl_we,
  input  logic [31:0]   ctrl_wdata,
  input  logic          blen_we,
  input  logic [CW-1:0] blen_wdata,
  input  logic          tlen_we,
  input  logic [CW-1:0] tlen_wdata,
  output logic [31:0]   ctrl_rdata,
  input  logic          txf_empty,
  input  logic [W-1:0]  txf_data,
  output logic          txf_pop,
  output logic          rxf_push,
  output logic [W-1:0]  rxf_data,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [N-1:0]  cs_lines,
  output logic          xfer_done
);
  xfer_cfg_t     cfg;
  logic [CW-1:0] burst_len, tx_len;
  logic          busy, go, active, loading, shifting, tx_pending;

  spi_cfg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .blen_we(blen_we), .blen_wdata(blen_wdata),
    .tlen_we(tlen_we), .tlen_wdata(tlen_wdata),
    .done(xfer_done), .cfg(cfg), .burst_len(burst_len), .tx_len(tx_len),
    .busy(busy), .go(go), .ctrl_rdata(ctrl_rdata)
  );

  spi_shift_core #(.W(W), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .cfg(cfg),
    .burst_len(burst_len), .tx_len(tx_len),
    .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
    .miso(miso), .rxf_push(rxf_push), .rxf_data(rxf_data),
    .sclk(sclk), .mosi(mosi), .active(active), .done(xfer_done),
    .loading(loading), .shifting(shifting), .tx_pending(tx_pending)
  );

  spi_cs_gen #(.N(N)) u_cs (
    .cfg(cfg), .active(active), .cs_lines(cs_lines)
  );
endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         txf_empty,
  input logic         txf_pop,
  input logic         xfer_done,
  input logic         busy,
  input logic         sclk,
  input logic         cpol,
  input logic         cs_low,
  input logic         cs_man,
  input logic         loading,
  input logic         shifting,
  input logic         tx_pending,
  input logic [N-1:0] cs_lines
);
  // R10
  pop_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty);

  // R5
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> sclk == cpol);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done && !busy);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loading && tx_pending && txf_empty |=> !shifting);

  // R8
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cs_man |-> $countones(cs_low ? ~cs_lines : cs_lines) == 1);

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cpol));
endmodule

bind spi_burst_engine spi_burst_engine_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .txf_empty(txf_empty), .txf_pop(txf_pop),
  .xfer_done(xfer_done), .busy(busy), .sclk(sclk), .cpol(cfg.cpol),
  .cs_low(cfg.cs_low), .cs_man(cfg.cs_man), .loading(loading),
  .shifting(shifting), .tx_pending(tx_pending), .cs_lines(cs_lines)
);

// File: tb/spi_burst_engine_tb.sv
module spi_burst_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        ctrl_we = 1'b0, blen_we = 1'b0, tlen_we = 1'b0;
  logic [31:0] ctrl_wdata = '0, ctrl_rdata;
  logic [23:0] blen_wdata = '0, tlen_wdata = '0;
  logic        txf_empty, txf_pop, rxf_push, sclk, mosi, miso = 1'b0, xfer_done;
  logic [7:0]  txf_data, rxf_data;
  logic [3:0]  cs_lines;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_burst_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .blen_we(blen_we), .blen_wdata(blen_wdata),
    .tlen_we(tlen_we), .tlen_wdata(tlen_wdata),
    .ctrl_rdata(ctrl_rdata), .txf_empty(txf_empty), .txf_data(txf_data),
    .txf_pop(txf_pop), .rxf_push(rxf_push), .rxf_data(rxf_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_lines(cs_lines),
    .xfer_done(xfer_done)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // Transmit FIFO model and receive capture
  logic [7:0] tx_mem [64];
  logic [7:0] sl_mem [64];
  logic [7:0] rx_got [256];
  int rd = 0, avail = 0, tx_base = 0, rx_n = 0;
  assign txf_empty = (rd >= avail);
  assign txf_data  = tx_mem[(rd - tx_base) & 63];

  always @(posedge clk) begin
    if (rst_n) tick <= ~tick;
    if (txf_pop) rd <= rd + 1;
    if (rxf_push) begin
      rx_got[rx_n & 255] <= rxf_data;
      rx_n <= rx_n + 1;
    end
  end

  // Bench view of configuration
  int m_cpol = 0, m_cpha = 0, m_lsb = 0, m_cslo = 0, m_idx = 0, m_man = 0, m_lvl = 0;
  int lead_n = 0, trail_n = 0, shift_n = 0, cap_n = 0, done_n = 0, cs_bad = 0;
  int sh_base = 0, cap_base = 0;
  bit mon_cs = 0;
  bit cap_bits [512];
  logic prev_sclk = 1'b0;

  function automatic logic [3:0] exp_cs(input int busy);
    logic [3:0] v;
    for (int i = 0; i < 4; i++)
      v[i] = (i == m_idx) ? (m_man != 0 ? 1'(m_lvl) : 1'((busy ^ m_cslo) & 1))
                          : 1'(m_cslo);
    return v;
  endfunction

  // Slave model: counts edges, captures data out, drives data in
  always @(negedge clk) begin
    int bi;
    if (rst_n && ctrl_rdata[31] && sclk !== prev_sclk) begin
      if (sclk != 1'(m_cpol)) begin
        lead_n++;
        if (m_cpha == 0) begin cap_bits[(cap_n - cap_base) & 511] = mosi; cap_n++; end
        else shift_n++;
      end else begin
        trail_n++;
        if (m_cpha != 0) begin cap_bits[(cap_n - cap_base) & 511] = mosi; cap_n++; end
        else shift_n++;
      end
    end
    prev_sclk = sclk;
    bi = shift_n - sh_base - m_cpha;
    if (bi < 0) miso = 1'b0;
    else miso = m_lsb != 0 ? sl_mem[(bi / 8) & 63][bi % 8]
                           : sl_mem[(bi / 8) & 63][7 - (bi % 8)];
    if (rst_n && xfer_done) done_n++;
    if (mon_cs && cs_lines !== exp_cs(int'(ctrl_rdata[31]))) cs_bad++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int go, input int drop);
    return (32'(go) << 31) | (32'(m_lsb) << 12) | (32'(drop) << 8) |
           (32'(m_lvl) << 7) | (32'(m_man) << 6) | (32'(m_idx) << 4) |
           (32'(m_cslo) << 2) | (32'(m_cpol) << 1) | 32'(m_cpha);
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_lens(input int b, input int t);
    @(negedge clk); blen_we = 1'b1; tlen_we = 1'b1;
    blen_wdata = 24'(b); tlen_wdata = 24'(t);
    @(negedge clk); blen_we = 1'b0; tlen_we = 1'b0;
  endtask

  task automatic wait_done(input int base);
    while (done_n <= base) @(negedge clk);
  endtask

  task automatic run(input int cpol, input int cpha, input int lsb, input int cslo,
                     input int idx, input int drop, input int man, input int lvl,
                     input int b, input int t, input int stall_at, input int poke,
                     input int seed);
    int rx_base, d_base, e_base, npop, nexp, k;
    logic [7:0] got, expb;
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_cslo = cslo; m_idx = idx;
    m_man = man; m_lvl = lvl;
    wr_ctrl(ctrl_word(0, drop));
    wr_lens(b, t);
    for (int i = 0; i < 64; i++) begin
      tx_mem[i] = 8'((seed * 37 + i * 13 + 5) & 255);
      sl_mem[i] = 8'((seed * 91 + i * 29 + 3) & 255);
    end
    tx_base = rd;
    avail = rd + (stall_at >= 0 ? stall_at : t);
    rx_base = rx_n; d_base = done_n; e_base = lead_n + trail_n;
    sh_base = shift_n; cap_base = cap_n;
    wr_ctrl(ctrl_word(1, drop));
    mon_cs = 1;
    if (poke != 0) begin
      repeat (6) @(negedge clk);
      wr_ctrl(ctrl_word(0, drop) ^ 32'h2);
      // R11: control write while busy leaves the fields unchanged
      chk(ctrl_rdata == ctrl_word(1, drop), "R11 ignored write", int'(ctrl_rdata[15:0]),
          int'(ctrl_word(1, drop) & 32'hffff));
    end
    if (stall_at >= 0) begin
      while (lead_n + trail_n - e_base < 16 * stall_at) @(negedge clk);
      repeat (40) @(negedge clk);
      // R10: engine waits with sclk idle and no extra edges
      chk(lead_n + trail_n - e_base == 16 * stall_at, "R10 stall edges",
          lead_n + trail_n - e_base, 16 * stall_at);
      chk(sclk == 1'(cpol), "R10 stall sclk level", int'(sclk), cpol);
      chk(rd - tx_base == stall_at, "R10 stall pops", rd - tx_base, stall_at);
      avail = tx_base + t;
    end
    wait_done(d_base);
    mon_cs = 0;
    repeat (3) @(negedge clk);
    npop = (t < b) ? t : b;
    // R3: edge count, single done pulse, busy cleared
    chk(lead_n + trail_n - e_base == 16 * b, "R3 edge count", lead_n + trail_n - e_base, 16 * b);
    chk(done_n - d_base == 1, "R3 done pulses", done_n - d_base, 1);
    chk(ctrl_rdata[31] == 1'b0, "R3 start clears", int'(ctrl_rdata[31]), 0);
    // R4: pops
    chk(rd - tx_base == npop, "R4 pop count", rd - tx_base, npop);
    // R8 R9: chip-select lines during the burst
    chk(cs_bad == 0, man != 0 ? "R9 manual cs in burst" : "R8 auto cs", cs_bad, 0);
    cs_bad = 0;
    // R4 R5 R6: bytes on the wire
    for (int j = 0; j < b; j++) begin
      got = '0;
      for (int p = 0; p < 8; p++)
        if (lsb != 0) got[p] = cap_bits[(j * 8 + p) & 511];
        else          got[7 - p] = cap_bits[(j * 8 + p) & 511];
      expb = (j < t) ? tx_mem[j] : 8'h00;
      chk(got == expb, "R4 R5 R6 mosi byte", int'(got), int'(expb));
    end
    // R7 R5 R6: received bytes
    nexp = 0;
    for (int j = 0; j < b; j++) if (!(drop != 0 && j < t)) nexp++;
    chk(rx_n - rx_base == nexp, "R7 push count", rx_n - rx_base, nexp);
    k = 0;
    for (int j = 0; j < b; j++) begin
      if (!(drop != 0 && j < t)) begin
        got = rx_got[(rx_base + k) & 255];
        chk(got == sl_mem[j], "R5 R6 R7 rx byte", int'(got), int'(sl_mem[j]));
        k++;
      end
    end
  endtask

  initial begin
    int d_base, e_base, r_base;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({sclk, mosi, cs_lines, txf_pop, rxf_push, xfer_done} == '0, "R1 outputs",
        int'({sclk, mosi, cs_lines, txf_pop, rxf_push, xfer_done}), 0);
    chk(ctrl_rdata == '0, "R1 ctrl_rdata", int'(ctrl_rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: readback places every field
    m_cpha = 1; m_cpol = 1; m_cslo = 1; m_idx = 3; m_man = 0; m_lvl = 1; m_lsb = 1;
    wr_ctrl(ctrl_word(0, 1) | 32'h0000_e000);
    chk(ctrl_rdata == ctrl_word(0, 1), "R2 field readback", int'(ctrl_rdata),
        int'(ctrl_word(0, 1)));
    chk(sclk == 1'b1, "R5 idle level follows bit 1", int'(sclk), 1);

    // Sweep: clock modes x bit order x length patterns
    for (int md = 0; md < 4; md++)
      for (int lb = 0; lb < 2; lb++)
        for (int pc = 0; pc < 5; pc++) begin
          int b, t, dr;
          case (pc)
            0: begin b = 3; t = 3; dr = 0; end
            1: begin b = 4; t = 2; dr = 0; end
            2: begin b = 4; t = 2; dr = 1; end
            3: begin b = 2; t = 0; dr = 1; end
            default: begin b = 2; t = 5; dr = 0; end
          endcase
          run(md >> 1, md & 1, lb, lb, md, dr, 0, 0, b, t, -1, 0, md * 10 + lb * 5 + pc);
        end

    // R10: FIFO runs dry after the first byte
    run(1, 0, 0, 1, 2, 0, 0, 0, 3, 3, 1, 0, 77);
    // R11: control write during the burst
    run(0, 1, 1, 0, 1, 0, 0, 0, 3, 3, -1, 1, 55);
    // R9: manual select held through a burst
    run(0, 0, 0, 1, 2, 0, 1, 0, 2, 2, -1, 0, 33);

    // R9: manual level without a burst
    m_cslo = 1; m_idx = 2; m_man = 1; m_lvl = 1;
    wr_ctrl(ctrl_word(0, 0));
    chk(cs_lines == 4'b1111, "R9 manual level high", int'(cs_lines), 15);
    m_lvl = 0;
    wr_ctrl(ctrl_word(0, 0));
    chk(cs_lines == 4'b1011, "R9 manual level low", int'(cs_lines), 11);
    m_cslo = 0; m_lvl = 1; m_idx = 1;
    wr_ctrl(ctrl_word(0, 0));
    chk(cs_lines == 4'b0010, "R9 manual active-high idle", int'(cs_lines), 2);
    m_man = 0; m_lvl = 0;
    wr_ctrl(ctrl_word(0, 0));
    chk(cs_lines == 4'b0000, "R8 idle lines", int'(cs_lines), 0);

    // R12: zero-length burst
    wr_lens(0, 3);
    avail = rd + 3;
    d_base = done_n; e_base = lead_n + trail_n; r_base = rx_n;
    wr_ctrl(ctrl_word(1, 0));
    repeat (6) @(negedge clk);
    chk(done_n - d_base == 1, "R12 done pulse", done_n - d_base, 1);
    chk(lead_n + trail_n == e_base, "R12 no edges", lead_n + trail_n - e_base, 0);
    chk(rx_n == r_base && rd == avail - 3, "R12 no fifo traffic", rx_n - r_base, 0);
    chk(ctrl_rdata[31] == 1'b0, "R12 busy clear", int'(ctrl_rdata[31]), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule